// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is the slave side of a two-wire serial memory. It sits behind already filtered and synchronised clock and data lines, decodes START and STOP conditions, and answers a master that addresses it with device code 1010. Behind the bus logic sits a byte-wide memory, modelled as a register array of 128 or 256 entries, chosen by parameter.

Writes do not reach the array directly. Data bytes land in a small page buffer that wraps inside its aligned page. A STOP that closes a clean write frame launches a self-timed commit, modelled as a cycle counter that replaces the real cell write time. While the commit runs, the slave stays silent on the bus, and a write-protect pin can veto the commit so that the whole array stays unchanged. Reads come in three flavours: from the current pointer, from a freshly loaded word address through a repeated START, and as a sequential stream that walks and wraps the pointer.

Top module: `eep_slave`

## Requirements
- R1: A control byte whose upper nibble is 1010 gets an acknowledge: SDA is held low from the fall after the eighth clock through the whole high phase of the ninth. Bits 3:1 are don't-care and bit 0 selects read (1) or write (0). Any other nibble gets no acknowledge.
- R2: In a write frame, the byte after the control byte is the word address. It is acknowledged and loads the internal pointer.
- R3: Data bytes of a write frame are acknowledged and buffered. On a STOP at a byte boundary they are written to consecutive addresses starting at the word address, and a frame with no data bytes commits nothing.
- R4: The buffer index wraps inside the aligned 8-byte page: address bits above bit 2 never change during one page load.
- R5: When more than 8 data bytes arrive, later bytes overwrite earlier ones, so only the last 8 survive.
- R6: busy_o is high for exactly WR_CYCLES clock cycles after the STOP that launches a commit. While it is high the slave acknowledges nothing, not even its own control byte.
- R7: If wp_i is high at STOP, no location changes and busy_o stays low.
- R8: A random read (write control byte, word address, repeated START, read control byte) returns the addressed byte, MSB first.
- R9: During a read the pointer advances after each byte and wraps from the last location to 0.
- R10: A missing master acknowledge after a read byte ends the read, and the slave releases SDA so that the master can issue STOP.
- R11: A read frame without a word address starts at the current pointer, which is the location after the last byte read.
- R12: A START or STOP arriving after two or more bits of a byte aborts the frame, and an aborted write commits nothing.
- R13: After reset the slave releases SDA and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level as seen on the wire |
| wp_i | input | 1 | Write-protect; high blocks any commit |
| sda_pull_o | output | 1 | Open-drain control: 1 pulls SDA low |
| busy_o | output | 1 | High while a self-timed commit runs |

## Verification
The assertions take for granted that the bus is well formed: SDA moves only while SCL is low, except for deliberate START and STOP edges, and every SCL low and high phase lasts several system clocks, so that a registered change in the pull output lands inside the low phase. They also assume that the master never drives SDA low against a data bit in which the slave itself is pulling the line. The bench keeps to this by driving each quarter bit for four system clocks, changing data only after a falling SCL edge, and modelling the line as the wired AND of master and slave.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDAT, ST_RDAT, ST_ACK, ST_MACK
  } eep_state_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int AW    = 8,
  parameter int PAGE  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              base_ld_i,
  input  logic [AW-1:0]     base_i,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  output logic [AW-1:0]     base_o,
  output logic [PAGE*8-1:0] data_o,
  output logic [PAGE-1:0]   valid_o,
  output logic              any_o
);
  localparam int PB = $clog2(PAGE);

  logic [PB-1:0]     idx_q, idx_d;
  logic [AW-1:0]     base_q, base_d;
  logic [PAGE-1:0]   valid_q, valid_d;
  logic [PAGE*8-1:0] data_q;

  always_comb begin
    idx_d   = idx_q;
    base_d  = base_q;
    valid_d = valid_q;
    if (clr_i) begin
      valid_d = '0;
    end else if (base_ld_i) begin
      base_d  = base_i;
      idx_d   = base_i[PB-1:0];
      valid_d = '0;
    end else if (push_i) begin
      valid_d[idx_q] = 1'b1;
      idx_d          = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      base_q  <= '0;
      valid_q <= '0;
    end else begin
      idx_q   <= idx_d;
      base_q  <= base_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i && !base_ld_i) data_q[idx_q*8 +: 8] <= push_data_i;
  end

  assign base_o  = base_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign any_o   = |valid_q;

  // R3: an accepted byte leaves the buffer non-empty
  assert_push_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i && !base_ld_i) |=> any_o);
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R6: the bus side never relaunches a commit that is still running
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i);
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int MEM_BYTES = 256,
  parameter int AW        = 8,
  parameter int PAGE      = 8
) (
  input  logic              clk,
  input  logic              commit_i,
  input  logic [AW-1:0]     base_i,
  input  logic [PAGE*8-1:0] data_i,
  input  logic [PAGE-1:0]   valid_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int PB = $clog2(PAGE);

  logic [7:0] rd_vec [MEM_BYTES];

  for (genvar i = 0; i < MEM_BYTES; i++) begin : g_loc
    localparam logic [AW-1:0] LA = AW'(i);
    logic       hit;
    logic [7:0] cell_q;
    assign hit = commit_i && valid_i[LA[PB-1:0]] && (LA[AW-1:PB] == base_i[AW-1:PB]);
    always_ff @(posedge clk) begin
      if (hit) cell_q <= data_i[LA[PB-1:0]*8 +: 8];
    end
    assign rd_vec[i] = cell_q;
  end

  assign rd_data_o = rd_vec[rd_addr_i];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic start_c, stop_c, rise_c, fall_c;
  logic buf_clr, buf_base_ld, buf_push, buf_any, tmr_start, done;
  logic [AW-1:0]           buf_base;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_valid;
  logic [7:0]              rd_data;

  eep_state_e st_q, st_d, nxt_q, nxt_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d, ob_q, ob_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          nack_q, nack_d, pull_q, pull_d;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_c), .stop_o(stop_c), .rise_o(rise_c), .fall_o(fall_c)
  );

  eep_page_buf #(.AW(AW), .PAGE(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_s_n), .clr_i(buf_clr | done),
    .base_ld_i(buf_base_ld), .base_i(sh_q[AW-1:0]),
    .push_i(buf_push), .push_data_i(sh_q),
    .base_o(buf_base), .data_o(buf_data), .valid_o(buf_valid), .any_o(buf_any)
  );

  eep_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .start_i(tmr_start), .busy_o(busy_o), .done_o(done)
  );

  eep_cell_array #(.MEM_BYTES(MEM_BYTES), .AW(AW), .PAGE(PAGE_BYTES)) u_arr (
    .clk(clk), .commit_i(done), .base_i(buf_base), .data_i(buf_data),
    .valid_i(buf_valid), .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  always_comb begin
    st_d = st_q;  nxt_d = nxt_q;  bit_d = bit_q;  sh_d = sh_q;
    ob_d = ob_q;  ptr_d = ptr_q;  nack_d = nack_q;
    buf_clr = 1'b0;  buf_base_ld = 1'b0;  buf_push = 1'b0;  tmr_start = 1'b0;
    if (start_c) begin
      st_d  = ST_CTRL;
      bit_d = '0;
      buf_clr = !busy_o;
    end else if (stop_c) begin
      st_d = ST_IDLE;
      if (st_q == ST_WDAT && bit_q < 4'd2 && buf_any && !busy_o && !wp_i) tmr_start = 1'b1;
      else buf_clr = !busy_o;
    end else begin
      case (st_q)
        ST_CTRL, ST_ADDR, ST_WDAT: begin
          if (rise_c) begin
            sh_d  = {sh_q[6:0], sda_i};
            bit_d = bit_q + 1'b1;
          end else if (fall_c && bit_q == 4'd8) begin
            bit_d = '0;
            st_d  = ST_ACK;
            nxt_d = ST_WDAT;
            if (st_q == ST_CTRL) begin
              if (sh_q[7:4] != DEV_CODE || busy_o) st_d = ST_IDLE;
              else nxt_d = sh_q[0] ? ST_RDAT : ST_ADDR;
            end else if (st_q == ST_ADDR) begin
              ptr_d       = sh_q[AW-1:0];
              buf_base_ld = 1'b1;
            end else begin
              buf_push = 1'b1;
            end
          end
        end
        ST_ACK: if (fall_c) begin
          st_d  = nxt_q;
          bit_d = '0;
          if (nxt_q == ST_RDAT) begin
            ob_d  = rd_data;
            ptr_d = ptr_q + 1'b1;
          end
        end
        ST_RDAT: begin
          if (rise_c) bit_d = bit_q + 1'b1;
          else if (fall_c && bit_q == 4'd8) begin
            st_d  = ST_MACK;
            bit_d = '0;
          end else if (fall_c && bit_q != 4'd0) ob_d = {ob_q[6:0], 1'b1};
        end
        ST_MACK: begin
          if (rise_c) nack_d = sda_i;
          else if (fall_c) begin
            if (nack_q) st_d = ST_IDLE;
            else begin
              st_d  = ST_RDAT;
              bit_d = '0;
              ob_d  = rd_data;
              ptr_d = ptr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    pull_d = (st_d == ST_ACK) || (st_d == ST_RDAT && !ob_d[7]);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_IDLE;  nxt_q <= ST_IDLE;  bit_q <= '0;  sh_q <= '0;
      ob_q <= 8'hFF;    ptr_q <= '0;       nack_q <= 1'b1;  pull_q <= 1'b0;
    end else begin
      st_q <= st_d;  nxt_q <= nxt_d;  bit_q <= bit_d;  sh_q <= sh_d;
      ob_q <= ob_d;  ptr_q <= ptr_d;  nack_q <= nack_d;  pull_q <= pull_d;
    end
  end

  assign sda_pull_o = pull_q;

  // R1: the pull level only moves while SCL is low
  assert_pull_steady_high_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));
  // R6: no acknowledge or data drive while a commit runs
  assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o |-> !sda_pull_o);
  // R7: a commit only launches with write-protect low
  assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy_o) |-> !$past(wp_i));
  // R10: once the frame has ended the line is left free
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !sda_pull_o);
endmodule

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
  localparam int WRC = 400;
  localparam int Q   = 4;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, wp;
  logic pull, busy;
  logic sda_line;
  int checks = 0, fails = 0;

  assign sda_line = sda_m & ~pull;
  always #10 clk = ~clk;

  eep_slave #(.MEM_BYTES(256), .PAGE_BYTES(8), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_pull_o(pull), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(1); a0 = sda_line;
    wq(Q - 1); a1 = sda_line; scl_m = 1'b0; wq(Q);
    acked = !a0 && !a1;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(2); d[i] = sda_line; wq(Q - 2); scl_m = 1'b0;
    end
    wq(1); sda_m = !ack; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4 * WRC) begin wq(1); n++; end
  endtask

  task automatic write_frame(input logic [7:0] addr, input logic [7:0] d [16], input int n,
                             input string req);
    logic a;
    i2c_start();
    wr_byte(8'hA0, a); chk({req, " ctrl ack"}, a, 1);
    wr_byte(addr, a);  chk({req, " addr ack R2"}, a, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(d[i], a);
      if (!a) chk({req, " data ack R3"}, a, 1);
    end
  endtask

  task automatic stop_measure(output int cyc);
    bit seen = 0;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1;
    cyc = 0;
    for (int i = 0; i < 2 * WRC + 50; i++) begin
      wq(1);
      if (busy) begin cyc++; seen = 1; end
      else if (seen) break;
    end
  endtask

  task automatic read_check(input logic [7:0] addr, input logic [7:0] e [16], input int n,
                            input string req);
    logic a;
    logic [7:0] d;
    i2c_start();
    wr_byte(8'hA0, a); wr_byte(addr, a);
    i2c_start();
    wr_byte(8'hA1, a); chk({req, " read ctrl ack R8"}, a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      chk(req, d, e[i]);
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R13 pull after reset", pull, 0);
    chk("R13 busy after reset", busy, 0);
  endtask

  task automatic t_select();
    logic a;
    int cyc;
    i2c_start(); wr_byte(8'h90, a); chk("R1 foreign code nack", a, 0); i2c_stop();
    i2c_start(); wr_byte(8'hAE, a); chk("R1 select bits ignored", a, 1);
    wr_byte(8'h05, a); chk("R2 word address ack", a, 1);
    stop_measure(cyc); chk("R3 empty frame no commit", cyc, 0);
  endtask

  task automatic t_page();
    logic [7:0] d [16];
    int cyc;
    for (int i = 0; i < 16; i++) d[i] = 8'hA0 + 8'(i);
    write_frame(8'h10, d, 8, "R3");
    stop_measure(cyc); chk("R6 busy length", cyc, WRC);
    read_check(8'h10, d, 8, "R3 R8 page readback");
  endtask

  task automatic t_busy_nack();
    logic [7:0] d [16];
    logic a;
    for (int i = 0; i < 16; i++) d[i] = 8'h60 + 8'(i);
    write_frame(8'h70, d, 1, "R6");
    i2c_stop();
    i2c_start(); wr_byte(8'hA0, a); chk("R6 nack while busy", a, 0);
    i2c_stop();
    wait_idle();
  endtask

  task automatic t_wrap();
    logic [7:0] d [16], e [16];
    int cyc;
    for (int i = 0; i < 16; i++) d[i] = 8'h31 + 8'(i);
    write_frame(8'h1E, d, 4, "R4");
    stop_measure(cyc);
    e[0] = 8'h33; e[1] = 8'h34;
    read_check(8'h18, e, 2, "R4 page wrap low end");
    read_check(8'h1E, d, 2, "R4 page wrap high end");
  endtask

  task automatic t_over();
    logic [7:0] d [16], e [16];
    int cyc;
    for (int i = 0; i < 16; i++) d[i] = 8'h50 + 8'(i);
    write_frame(8'h20, d, 10, "R5");
    stop_measure(cyc);
    e[0] = 8'h58; e[1] = 8'h59;
    for (int i = 2; i < 8; i++) e[i] = 8'h50 + 8'(i);
    read_check(8'h20, e, 8, "R5 overwrite");
  endtask

  task automatic t_wp();
    logic [7:0] d [16], e [16];
    int cyc;
    d[0] = 8'hEE; e[0] = 8'hA0;
    wp = 1'b1;
    write_frame(8'h10, d, 1, "R7");
    stop_measure(cyc); chk("R7 no busy under protect", cyc, 0);
    wp = 1'b0;
    read_check(8'h10, e, 1, "R7 location unchanged");
  endtask

  task automatic t_seqwrap();
    logic [7:0] d [16], e [16];
    int cyc;
    for (int i = 0; i < 16; i++) d[i] = 8'hC0 + 8'(i);
    write_frame(8'hF8, d, 8, "R9"); stop_measure(cyc);
    for (int i = 0; i < 16; i++) d[i] = 8'hD0 + 8'(i);
    write_frame(8'h00, d, 8, "R9"); stop_measure(cyc);
    e[0] = 8'hC6; e[1] = 8'hC7; e[2] = 8'hD0; e[3] = 8'hD1;
    read_check(8'hFE, e, 4, "R9 sequential wrap");
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] d;
    i2c_start(); wr_byte(8'hA0, a); wr_byte(8'h10, a);
    i2c_start(); wr_byte(8'hA1, a);
    rd_byte(1'b1, d); chk("R8 first byte", d, 8'hA0);
    rd_byte(1'b0, d); chk("R8 second byte", d, 8'hA1);
    wq(2);
    chk("R10 pull released after nack", pull, 0);
    chk("R10 line high after nack", sda_line, 1);
    i2c_stop();
    i2c_start(); wr_byte(8'hA1, a); chk("R11 current read ack", a, 1);
    rd_byte(1'b0, d); chk("R11 current address data", d, 8'hA2);
    i2c_stop();
  endtask

  task automatic t_abort();
    logic [7:0] d [16], e [16];
    logic a;
    int cyc;
    d[0] = 8'h11; e[0] = 8'h11;
    write_frame(8'h40, d, 1, "R12"); stop_measure(cyc);
    i2c_start(); wr_byte(8'hA0, a); wr_byte(8'h40, a);
    wr_byte(8'h77, a); chk("R12 byte before abort acked", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    stop_measure(cyc); chk("R12 aborted write no busy", cyc, 0);
    read_check(8'h40, e, 1, "R12 location unchanged");
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_select();
    t_page();
    t_busy_nack();
    t_wrap();
    t_over();
    t_wp();
    t_seqwrap();
    t_current();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule